// File: doc/BRIEF.md
# Clocked Serial Word Port with Sticky Line Errors

This block moves 8-bit words between two on-chip FIFOs and a clocked serial line. Software loads outgoing words into a transmit FIFO with a write strobe and drains incoming words from a receive FIFO with a read strobe. While `port_en` is high, a divider on the system clock produces a serial clock, and the port runs back-to-back word slots of eight serial clocks each. In every slot it shifts one word out and one word in, most significant bit first.

Two sticky error flags are reported in a small status vector. The receive-overrun flag is set when a received word finds the receive FIFO full, and that word is discarded. The flag does not show which word was lost. A strobe on the end-of-frame clear input clears it. The transmit-underflow flag is set when a slot begins and there is no word to send. The next write into the transmit FIFO clears it. The serial data output is driven only while a word is being shifted out. At all other times its output enable is low. An interrupt line stays high while received data is waiting.

Top module: `sync_serial_port`

## Requirements
- R1: While `port_en` is high, `sclk` toggles every DIV_HALF system clocks (default 2), starting low. While `port_en` is low, `sclk` is held low.
- R2: Serial data is sent and received most significant bit first. `sdo` changes in the same system cycle that `sclk` rises. `sdi` is sampled in the system cycle where `sclk` falls. Eight `sclk` periods form one word slot.
- R3: `sdo_oe` goes high at the rising edge that starts a slot with a word to send. It goes low at the falling edge of that word's eighth bit, and also in a slot with no word. It is low whenever the port is disabled.
- R4: If a slot starts while the transmit FIFO is empty, `status[1]` (underflow) is set, nothing is driven in that slot, and the flag stays set.
- R5: A `tx_wr` strobe clears `status[1]`. If the strobe coincides with a slot start that finds the FIFO empty, the flag ends up set.
- R6: Each completed received word is appended to the receive FIFO. If the FIFO is full at that moment, the word is discarded and `status[0]` (overrun) is set and stays set.
- R7: An `eof_wr` strobe clears `status[0]`. A coinciding overrun wins.
- R8: The status bits are: bit 0 overrun, bit 1 underflow, bit 2 receive FIFO not empty, bit 3 transmit FIFO full. `rx_irq` equals receive-FIFO-not-empty.
- R9: Both FIFOs hold 16 words. A write to a full FIFO is dropped. A read of an empty FIFO has no effect. `tx_level` and `rx_level` give the current occupancy. `rx_rdata` shows the oldest received word.
- R10: Dropping `port_en` in the middle of a word abandons it. `sclk` and `sdo_oe` go low, no partial word enters the receive FIFO, and the next enable starts a fresh slot.
- R11: After reset, both FIFOs are empty, both flags are clear, and `sclk`, `sdo_oe` and `rx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Runs the serial clock and word slots |
| tx_wr | input | 1 | Write strobe into the transmit FIFO |
| tx_wdata | input | 8 | Word to transmit |
| rx_rd | input | 1 | Read strobe that removes the oldest received word |
| rx_rdata | output | 8 | Oldest received word |
| eof_wr | input | 1 | End-of-frame strobe that clears overrun |
| status | output | 4 | Overrun, underflow, rx-not-empty, tx-full |
| rx_irq | output | 1 | Received data is waiting |
| tx_level | output | 5 | Transmit FIFO occupancy |
| rx_level | output | 5 | Receive FIFO occupancy |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data in |

## Verification
The port is first run with an empty transmit FIFO, which separates the underflow path from normal shifting. Next, a few distinct words are loaded, which exposes bit-order and edge-placement errors. The receive FIFO is then allowed to fill while it is only partly drained, which exercises discard-on-full and the sticky overrun flag and its clear. A burst of twenty writes probes the dropped-when-full rule and the tx-full bit. Finally, a mid-word disable distinguishes abandoning a word from completing it. The serial input is random throughout, so received words differ from slot to slot.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int ST_OVR    = 0;
  localparam int ST_UDF    = 1;
  localparam int ST_RXNE   = 2;
  localparam int ST_TXFULL = 3;
  localparam int ST_W      = 4;
endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  // storage without reset so the array maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  assert_full_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(level));
  assert_empty_read_harmless_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (level == '0));
endmodule

// File: rtl/sport_clkdiv.sv
module sport_clkdiv #(
  parameter int DIV_HALF = 2,
  localparam int CNTW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sclk,
  output logic rise_p,
  output logic fall_p
);
  logic [CNTW-1:0] cnt;
  logic wrap;

  assign wrap   = (cnt == CNTW'(DIV_HALF-1));
  assign rise_p = en && wrap && !sclk;
  assign fall_p = en && wrap && sclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= !sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  assert_sclk_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sclk);
  assert_sclk_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    (rise_p || fall_p) |=> (sclk != $past(sclk)));
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter #(
  parameter int WORD = 8,
  localparam int BW = (WORD > 1) ? $clog2(WORD) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            rise_p,
  input  logic            fall_p,
  input  logic            tx_avail,
  input  logic [WORD-1:0] tx_word,
  input  logic            sdi,
  output logic            tx_take,
  output logic            tx_starve,
  output logic            rx_done,
  output logic [WORD-1:0] rx_word,
  output logic            sdo,
  output logic            sdo_oe
);
  logic [BW-1:0]   bitn;
  logic [WORD-1:0] txsh, rxsh, rx_next;
  logic            slot_start;

  assign slot_start = rise_p && (bitn == '0);
  assign tx_take    = slot_start && tx_avail;
  assign tx_starve  = slot_start && !tx_avail;
  assign rx_next    = {rxsh[WORD-2:0], sdi};
  assign rx_done    = fall_p && (bitn == BW'(WORD-1));
  assign rx_word    = rx_next;
  assign sdo        = txsh[WORD-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bitn   <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      sdo_oe <= 1'b0;
    end else if (!en) begin
      bitn   <= '0;
      sdo_oe <= 1'b0;
    end else begin
      if (rise_p) begin
        if (bitn == '0) begin
          sdo_oe <= tx_avail;
          if (tx_avail) txsh <= tx_word;
        end else begin
          txsh <= {txsh[WORD-2:0], 1'b0};
        end
      end
      if (fall_p) begin
        rxsh <= rx_next;
        if (bitn == BW'(WORD-1)) begin
          bitn   <= '0;
          sdo_oe <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
        end
      end
    end
  end

  assert_oe_off_when_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sdo_oe);
  assert_oe_after_load_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_take && en) |=> sdo_oe);
  assert_no_drive_on_starve_R4: assert property (@(posedge clk) disable iff (rst)
    tx_starve |=> !sdo_oe);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import sport_pkg::*;
#(
  parameter int WORD       = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_HALF   = 2,
  localparam int LW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            port_en,
  input  logic            tx_wr,
  input  logic [WORD-1:0] tx_wdata,
  input  logic            rx_rd,
  output logic [WORD-1:0] rx_rdata,
  input  logic            eof_wr,
  output logic [ST_W-1:0] status,
  output logic            rx_irq,
  output logic [LW-1:0]   tx_level,
  output logic [LW-1:0]   rx_level,
  output logic            sclk,
  output logic            sdo,
  output logic            sdo_oe,
  input  logic            sdi
);
  logic rise_p, fall_p;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_take, tx_starve, rx_done;
  logic [WORD-1:0] tx_head, rx_word;
  logic ovr_q, udf_q;

  sport_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .en(port_en),
    .sclk(sclk), .rise_p(rise_p), .fall_p(fall_p)
  );

  sport_fifo #(.WIDTH(WORD), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_wr), .push_data(tx_wdata),
    .pop(tx_take), .head(tx_head), .full(tx_full), .empty(tx_empty),
    .level(tx_level)
  );

  sport_fifo #(.WIDTH(WORD), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_done), .push_data(rx_word),
    .pop(rx_rd), .head(rx_rdata), .full(rx_full), .empty(rx_empty),
    .level(rx_level)
  );

  sport_shifter #(.WORD(WORD)) u_shift (
    .clk(clk), .rst(rst), .en(port_en), .rise_p(rise_p), .fall_p(fall_p),
    .tx_avail(!tx_empty), .tx_word(tx_head), .sdi(sdi),
    .tx_take(tx_take), .tx_starve(tx_starve), .rx_done(rx_done),
    .rx_word(rx_word), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // sticky flags: a new error event outranks its clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (rx_done && rx_full) ovr_q <= 1'b1;
      else if (eof_wr)        ovr_q <= 1'b0;
      if (tx_starve)          udf_q <= 1'b1;
      else if (tx_wr)         udf_q <= 1'b0;
    end
  end

  always_comb begin
    status            = '0;
    status[ST_OVR]    = ovr_q;
    status[ST_UDF]    = udf_q;
    status[ST_RXNE]   = !rx_empty;
    status[ST_TXFULL] = tx_full;
  end
  assign rx_irq = !rx_empty;

  assert_udf_set_R4: assert property (@(posedge clk) disable iff (rst)
    tx_starve |=> status[ST_UDF]);
  assert_udf_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && !tx_starve) |=> !status[ST_UDF]);
  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (status[ST_OVR] && !eof_wr) |=> status[ST_OVR]);
  assert_ovr_on_full_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_full && !rx_rd) |=> (status[ST_OVR] && $stable(rx_level)));
  assert_ovr_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    (eof_wr && !(rx_done && rx_full)) |=> !status[ST_OVR]);
  assert_irq_matches_R8: assert property (@(posedge clk) disable iff (rst)
    rx_irq == (rx_level != '0));
endmodule

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;
  localparam int D = 2;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 1'b0;
  logic tx_wr = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic rx_rd = 1'b0;
  logic eof_wr = 1'b0;
  logic sdi = 1'b0;
  logic [7:0] rx_rdata;
  logic [3:0] status;
  logic rx_irq, sclk, sdo, sdo_oe;
  logic [4:0] tx_level, rx_level;

  always #2 clk = ~clk;

  sync_serial_port uut (
    .clk(clk), .rst(rst), .port_en(port_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .eof_wr(eof_wr), .status(status),
    .rx_irq(rx_irq), .tx_level(tx_level), .rx_level(rx_level), .sclk(sclk),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  int nvec = 0;
  int nfail = 0;

  // behavioural reference state
  int txq[$];
  int rxq[$];
  int m_cnt, m_word, m_pos, m_bit, m_rxw;
  bit m_sclk, m_oe, m_ovr, m_udf;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) sdi <= 1'($urandom);

  always @(posedge clk) begin
    if (rst) begin
      txq.delete(); rxq.delete();
      m_cnt = 0; m_word = 0; m_pos = 0; m_bit = 0; m_rxw = 0;
      m_sclk = 0; m_oe = 0; m_ovr = 0; m_udf = 0;
    end else begin
      bit wrap, rise, fall, take, starve, done;
      int tx_old, rx_old;
      wrap = (m_cnt == D-1);
      rise = port_en && wrap && !m_sclk;
      fall = port_en && wrap && m_sclk;
      tx_old = txq.size();
      rx_old = rxq.size();
      take = 0; starve = 0; done = 0;
      if (!port_en) begin
        m_cnt = 0; m_sclk = 0; m_bit = 0; m_oe = 0;
      end else begin
        if (wrap) begin m_cnt = 0; m_sclk = !m_sclk; end
        else m_cnt++;
        if (rise) begin
          if (m_bit == 0) begin
            if (tx_old > 0) begin take = 1; m_word = txq[0]; m_oe = 1; m_pos = 0; end
            else begin starve = 1; m_oe = 0; end
          end else m_pos = m_bit;
        end
        if (fall) begin
          m_rxw = ((m_rxw << 1) | int'(sdi)) & 255;
          if (m_bit == 7) begin done = 1; m_bit = 0; m_oe = 0; end
          else m_bit++;
        end
      end
      if (take) void'(txq.pop_front());
      if (tx_wr && tx_old < DEPTH) txq.push_back(int'(tx_wdata));
      if (rx_rd && rx_old > 0) void'(rxq.pop_front());
      if (done && rx_old < DEPTH) rxq.push_back(m_rxw);
      if (done && rx_old == DEPTH) m_ovr = 1;
      else if (eof_wr) m_ovr = 0;
      if (starve) m_udf = 1;
      else if (tx_wr) m_udf = 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 sclk", int'(sclk), int'(m_sclk));
      chk("R3 sdo_oe", int'(sdo_oe), int'(m_oe));
      if (m_oe) chk("R2 sdo bit", int'(sdo), (m_word >> (7 - m_pos)) & 1);
      chk("R6/R7 overrun", int'(status[0]), int'(m_ovr));
      chk("R4/R5 underflow", int'(status[1]), int'(m_udf));
      chk("R8 rx not empty", int'(status[2]), int'(rxq.size() != 0));
      chk("R8 tx full", int'(status[3]), int'(txq.size() == DEPTH));
      chk("R8 rx_irq", int'(rx_irq), int'(rxq.size() != 0));
      chk("R9 tx_level", int'(tx_level), txq.size());
      chk("R9 rx_level", int'(rx_level), rxq.size());
      if (rxq.size() != 0) chk("R2 rx word", int'(rx_rdata), rxq[0]);
    end
  end

  task automatic push_tx(input int v);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = 8'(v);
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic clear_ovr();
    @(negedge clk); eof_wr = 1'b1;
    @(negedge clk); eof_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 status", int'(status), 0);
    chk("R11 sclk", int'(sclk), 0);
    chk("R11 sdo_oe", int'(sdo_oe), 0);
    chk("R11 rx_irq", int'(rx_irq), 0);
    chk("R11 levels", int'({tx_level, rx_level}), 0);

    port_en = 1'b1;
    idle(40);                       // empty slots: underflow (R4)
    chk("R4 underflow set", int'(status[1]), 1);
    push_tx(8'hA5);                 // clears underflow (R5)
    push_tx(8'h3C);
    push_tx(8'hF0);
    idle(150);
    for (int i = 0; i < 4; i++) begin pop_rx(); idle(20); end
    idle(700);                      // rx fills up, overrun (R6)
    chk("R6 overrun set", int'(status[0]), 1);
    clear_ovr();                    // R7
    for (int i = 0; i < 16; i++) pop_rx();
    clear_ovr();
    chk("R7 overrun cleared", int'(status[0]), 0);
    for (int i = 0; i < 20; i++) push_tx(i * 37 + 5);   // R9 drops beyond 16
    chk("R8 tx full seen", int'(status[3]), 1);
    for (int i = 0; i < 10; i++) begin pop_rx(); idle(30); end
    idle(300);
    push_tx(8'h81);
    push_tx(8'h7E);
    while (!sdo_oe) @(negedge clk);
    idle(9);
    held = int'(rx_level);
    port_en = 1'b0;                 // R10 abandon mid-word
    idle(12);
    chk("R10 sclk low", int'(sclk), 0);
    chk("R10 oe low", int'(sdo_oe), 0);
    chk("R10 no partial word", int'(rx_level), held);
    port_en = 1'b1;
    idle(200);
    for (int i = 0; i < 16; i++) pop_rx();
    clear_ovr();
    idle(100);
    finish_run();
  end
endmodule